// File: doc/BRIEF.md
# Indirect Data Address Generator

This block forms the 12-bit data-memory address used by a small 8-bit microcontroller datapath on each operand access. An access either goes directly, with a 4-bit bank value placed above an 8-bit operand from the instruction, or indirectly through one of three pointer registers. For an indirect access, a 3-bit mode decides whether the pointer is used as it is, is read and then stepped down or up, is stepped up and then read, or is summed with the signed working-register value without being changed.

The address is combinational from the current state and the access inputs. Pointer changes take effect on the clock edge that ends the access, and only when the access strobe is high. Software-visible writes can set a pointer's low byte, the 4 stored bits of its high byte, or all 12 bits at once. A literal load sets the bank value. A byte-wide readback port returns any pointer to the datapath.

Top module: `ptr_addr_unit`

## Requirements
- R1: After a synchronous reset, all three pointers and the bank value read back as zero.
- R2: With `acc_indirect`=0 the address is `{bank_q, acc_operand}`, and `bank_load` replaces `bank_q` with `bank_value` on the next edge. A direct access never changes a pointer.
- R3: Mode code 0 (plain) gives the address equal to the selected pointer and leaves that pointer unchanged.
- R4: Mode code 1 (read then step down) gives the address equal to the pointer. After a strobed access the pointer is one less, modulo 4096, so 0x000 becomes 0xFFF.
- R5: Mode code 2 (read then step up) gives the address equal to the pointer. After a strobed access the pointer is one more, modulo 4096, so 0xFFF becomes 0x000.
- R6: Mode code 3 (step up then read) gives the address equal to the pointer plus one, modulo 4096, and after a strobed access the pointer holds that same value.
- R7: Mode code 4 (offset) gives the address equal to the pointer plus the sign-extended `acc_wreg`, modulo 4096. The pointer is left unchanged.
- R8: A pointer is modified by an access only when `acc_valid`=1 and `acc_indirect`=1. Only the pointer chosen by `acc_ptr` (codes 0, 1, 2) can change.
- R9: `ptr_wr_lo` writes `wr_byte` into bits 7:0 of the pointer chosen by `wr_ptr`, and `ptr_wr_hi` writes `wr_byte[3:0]` into bits 11:8. Both may be applied in the same cycle. `rd_hi` returns bits 11:8 with its upper 4 bits zero, and `rd_lo` returns bits 7:0 of the pointer chosen by `rd_sel`.
- R10: `ptr_load` sets all 12 bits of the pointer chosen by `wr_ptr` to `load_value` in a single edge.
- R11: When several updates target one pointer in the same cycle, a full load beats a byte write, and a byte write beats an access update. The losing updates are dropped. Updates to different pointers all take effect.
- R12: Mode codes 5, 6 and 7 behave exactly as plain mode.
- R13: Select code 3 names no pointer. An indirect access through it gives address 0 and changes nothing, writes and loads to it are dropped, and readback through it returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe; enables pointer modification |
| acc_indirect | input | 1 | 1 = indirect access through a pointer, 0 = direct |
| acc_ptr | input | 2 | Pointer used by the access |
| acc_mode | input | 3 | Access mode code |
| acc_wreg | input | 8 | Working-register value used as a signed offset |
| acc_operand | input | 8 | Operand byte for direct accesses |
| eff_addr | output | 12 | Effective data address |
| wr_ptr | input | 2 | Pointer targeted by byte writes and full loads |
| ptr_wr_hi | input | 1 | Write the high byte of the targeted pointer |
| ptr_wr_lo | input | 1 | Write the low byte of the targeted pointer |
| wr_byte | input | 8 | Data for byte writes |
| ptr_load | input | 1 | Load all 12 bits of the targeted pointer |
| load_value | input | 12 | Value for a full load |
| bank_load | input | 1 | Load the bank value |
| bank_value | input | 4 | New bank value |
| bank_q | output | 4 | Current bank value |
| rd_sel | input | 2 | Pointer chosen for readback |
| rd_hi | output | 8 | High byte of the chosen pointer |
| rd_lo | output | 8 | Low byte of the chosen pointer |

## Verification
A wrong pointer value shows at the ports in two ways. It appears on `rd_hi`/`rd_lo` right after the edge that wrote it, and it appears on `eff_addr` in the same cycle as the next indirect access through that pointer. So every update is compared against an arithmetic model right after its edge, before anything else can hide it. The sweep covers every select code, all eight mode codes, strobe on and off, and offsets at the sign boundary. Pointer start values are placed at 0x000, 0x7FF, 0x800 and 0xFFF so that wrap and sign errors show up at once. Same-cycle collisions between loads, byte writes and access updates are checked separately, because a priority error only appears when updates meet on one pointer.

// File: rtl/addrgen_pkg.sv
package addrgen_pkg;

    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 8;
    localparam int BANK_W  = ADDR_W - DATA_W;
    localparam int HI_W    = ADDR_W - DATA_W;
    localparam int MODE_W  = 3;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [BANK_W-1:0] bank_t;
    typedef logic [HI_W-1:0]   nib_t;

    typedef enum logic [MODE_W-1:0] {
        AM_PLAIN   = 3'd0,
        AM_POSTDEC = 3'd1,
        AM_POSTINC = 3'd2,
        AM_PREINC  = 3'd3,
        AM_OFFSET  = 3'd4
    } am_e;

    typedef struct packed {
        logic  modifies;
        addr_t next;
    } ptr_upd_t;

    // Working register widened as a two's complement value.
    function automatic addr_t sext_w(byte_t w);
        return addr_t'({{HI_W{w[DATA_W-1]}}, w});
    endfunction

    // Pointer value after a strobed access in the given mode.
    function automatic ptr_upd_t step_ptr(am_e m, addr_t p);
        ptr_upd_t u;
        case (m)
            AM_POSTDEC: begin u.modifies = 1'b1; u.next = p - addr_t'(1); end
            AM_POSTINC: begin u.modifies = 1'b1; u.next = p + addr_t'(1); end
            AM_PREINC:  begin u.modifies = 1'b1; u.next = p + addr_t'(1); end
            default:    begin u.modifies = 1'b0; u.next = p;              end
        endcase
        return u;
    endfunction

    // Address presented during an indirect access.
    function automatic addr_t indirect_ea(am_e m, addr_t p, byte_t w);
        case (m)
            AM_PREINC: return p + addr_t'(1);
            AM_OFFSET: return p + sext_w(w);
            default:   return p;
        endcase
    endfunction

endpackage

// File: rtl/ag_ptr_reg.sv
module ag_ptr_reg
    import addrgen_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load_en,
    input  addr_t load_val,
    input  logic  wr_hi,
    input  logic  wr_lo,
    input  nib_t  hi_nib,
    input  byte_t lo_byte,
    input  logic  upd_en,
    input  addr_t upd_val,
    output addr_t ptr_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (load_en) begin
            ptr_q <= load_val;
        end else if (wr_hi || wr_lo) begin
            if (wr_hi) ptr_q[ADDR_W-1:DATA_W] <= hi_nib;
            if (wr_lo) ptr_q[DATA_W-1:0]      <= lo_byte;
        end else if (upd_en) begin
            ptr_q <= upd_val;
        end
    end

    assert_full_load_R10: assert property (@(posedge clk) disable iff (rst)
        load_en |=> ptr_q == $past(load_val));

    assert_hi_write_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_hi && !load_en) |=> ptr_q[ADDR_W-1:DATA_W] == $past(hi_nib));

    assert_lo_beats_upd_R11: assert property (@(posedge clk) disable iff (rst)
        (wr_lo && !wr_hi && !load_en) |=> ptr_q[ADDR_W-1:DATA_W] == $past(ptr_q[ADDR_W-1:DATA_W]));

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!load_en && !wr_hi && !wr_lo && !upd_en) |=> $stable(ptr_q));

endmodule

// File: rtl/ag_bank_reg.sv
module ag_bank_reg
    import addrgen_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load_en,
    input  bank_t load_val,
    output bank_t bank_q
);

    always_ff @(posedge clk) begin
        if (rst)          bank_q <= '0;
        else if (load_en) bank_q <= load_val;
    end

    assert_bank_load_R2: assert property (@(posedge clk) disable iff (rst)
        load_en |=> bank_q == $past(load_val));

    assert_bank_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> $stable(bank_q));

endmodule

// File: rtl/ag_ea_calc.sv
module ag_ea_calc
    import addrgen_pkg::*;
(
    input  logic              indirect,
    input  logic              ptr_ok,
    input  logic [MODE_W-1:0] mode,
    input  addr_t             ptr_cur,
    input  byte_t             wreg,
    input  bank_t             bank,
    input  byte_t             operand,
    output addr_t             eff_addr,
    output logic              modifies,
    output addr_t             ptr_next
);

    am_e      m;
    ptr_upd_t u;

    always_comb begin
        m        = am_e'(mode);
        u        = step_ptr(m, ptr_cur);
        modifies = u.modifies & indirect & ptr_ok;
        ptr_next = u.next;
        if (!indirect)
            eff_addr = {bank, operand};
        else if (!ptr_ok)
            eff_addr = '0;
        else
            eff_addr = indirect_ea(m, ptr_cur, wreg);
    end

endmodule

// File: rtl/ptr_addr_unit.sv
module ptr_addr_unit
    import addrgen_pkg::*;
#(
    parameter int NUM_PTR = 3,
    parameter int SEL_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_indirect,
    input  logic [SEL_W-1:0]  acc_ptr,
    input  logic [MODE_W-1:0] acc_mode,
    input  logic [DATA_W-1:0] acc_wreg,
    input  logic [DATA_W-1:0] acc_operand,
    output logic [ADDR_W-1:0] eff_addr,
    input  logic [SEL_W-1:0]  wr_ptr,
    input  logic              ptr_wr_hi,
    input  logic              ptr_wr_lo,
    input  logic [DATA_W-1:0] wr_byte,
    input  logic              ptr_load,
    input  logic [ADDR_W-1:0] load_value,
    input  logic              bank_load,
    input  logic [BANK_W-1:0] bank_value,
    output logic [BANK_W-1:0] bank_q,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [DATA_W-1:0] rd_hi,
    output logic [DATA_W-1:0] rd_lo
);

    localparam logic [SEL_W-1:0] PTR_LAST = SEL_W'(NUM_PTR - 1);

    addr_t              ptr_q [NUM_PTR];
    logic [NUM_PTR-1:0] upd_vec;
    addr_t              cur_ptr;
    addr_t              rd_ptr;
    addr_t              ptr_next;
    logic               modifies;
    logic               ptr_ok;
    logic               rd_ok;

    assign ptr_ok = (acc_ptr <= PTR_LAST);
    assign rd_ok  = (rd_sel <= PTR_LAST);

    always_comb begin
        cur_ptr = '0;
        rd_ptr  = '0;
        for (int k = 0; k < NUM_PTR; k++) begin
            if (acc_ptr == SEL_W'(k)) cur_ptr = ptr_q[k];
            if (rd_sel  == SEL_W'(k)) rd_ptr  = ptr_q[k];
        end
    end

    ag_ea_calc u_ea (
        .indirect (acc_indirect),
        .ptr_ok   (ptr_ok),
        .mode     (acc_mode),
        .ptr_cur  (cur_ptr),
        .wreg     (acc_wreg),
        .bank     (bank_q),
        .operand  (acc_operand),
        .eff_addr (eff_addr),
        .modifies (modifies),
        .ptr_next (ptr_next)
    );

    ag_bank_reg u_bank (
        .clk      (clk),
        .rst      (rst),
        .load_en  (bank_load),
        .load_val (bank_value),
        .bank_q   (bank_q)
    );

    for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
        logic wsel;
        assign wsel       = (wr_ptr == SEL_W'(i));
        assign upd_vec[i] = acc_valid & modifies & (acc_ptr == SEL_W'(i));

        ag_ptr_reg u_ptr (
            .clk      (clk),
            .rst      (rst),
            .load_en  (ptr_load & wsel),
            .load_val (load_value),
            .wr_hi    (ptr_wr_hi & wsel),
            .wr_lo    (ptr_wr_lo & wsel),
            .hi_nib   (wr_byte[HI_W-1:0]),
            .lo_byte  (wr_byte),
            .upd_en   (upd_vec[i]),
            .upd_val  (ptr_next),
            .ptr_q    (ptr_q[i])
        );
    end

    assign rd_hi = rd_ok ? byte_t'(rd_ptr[ADDR_W-1:DATA_W]) : '0;
    assign rd_lo = rd_ok ? rd_ptr[DATA_W-1:0] : '0;

    // Strobed indirect access whose pointer sees no competing write.
    logic wr_hit;
    logic clean_acc;
    assign wr_hit    = (ptr_load | ptr_wr_hi | ptr_wr_lo) & (wr_ptr == acc_ptr);
    assign clean_acc = acc_valid & acc_indirect & ptr_ok & ~wr_hit;

    assert_one_update_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(upd_vec));

    assert_no_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        !(acc_valid && acc_indirect) |-> upd_vec == '0);

    assert_bad_sel_R13: assert property (@(posedge clk) disable iff (rst)
        (acc_indirect && !ptr_ok) |-> (eff_addr == '0 && upd_vec == '0));

    assert_preinc_match_R6: assert property (@(posedge clk) disable iff (rst)
        (clean_acc && acc_mode == AM_PREINC) |=> ptr_q[$past(acc_ptr)] == $past(eff_addr));

    assert_postdec_step_R4: assert property (@(posedge clk) disable iff (rst)
        (clean_acc && acc_mode == AM_POSTDEC) |=> ptr_q[$past(acc_ptr)] == $past(eff_addr) - addr_t'(1));

    assert_postinc_step_R5: assert property (@(posedge clk) disable iff (rst)
        (clean_acc && acc_mode == AM_POSTINC) |=> ptr_q[$past(acc_ptr)] == $past(eff_addr) + addr_t'(1));

    assert_offset_keep_R7: assert property (@(posedge clk) disable iff (rst)
        (clean_acc && acc_mode == AM_OFFSET) |=> ptr_q[$past(acc_ptr)] == $past(cur_ptr));

endmodule

// File: tb/sim_ptr_addr_unit.sv
module sim_ptr_addr_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        acc_valid, acc_indirect;
    logic [1:0]  acc_ptr;
    logic [2:0]  acc_mode;
    logic [7:0]  acc_wreg, acc_operand;
    logic [11:0] eff_addr;
    logic [1:0]  wr_ptr;
    logic        ptr_wr_hi, ptr_wr_lo, ptr_load, bank_load;
    logic [7:0]  wr_byte;
    logic [11:0] load_value;
    logic [3:0]  bank_value, bank_q;
    logic [1:0]  rd_sel;
    logic [7:0]  rd_hi, rd_lo;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [11:0] m_ptr [3];
    logic [3:0]  m_bank;

    always #10 clk = ~clk;

    ptr_addr_unit u0 (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_indirect(acc_indirect),
        .acc_ptr(acc_ptr), .acc_mode(acc_mode), .acc_wreg(acc_wreg),
        .acc_operand(acc_operand), .eff_addr(eff_addr), .wr_ptr(wr_ptr),
        .ptr_wr_hi(ptr_wr_hi), .ptr_wr_lo(ptr_wr_lo), .wr_byte(wr_byte),
        .ptr_load(ptr_load), .load_value(load_value), .bank_load(bank_load),
        .bank_value(bank_value), .bank_q(bank_q), .rd_sel(rd_sel),
        .rd_hi(rd_hi), .rd_lo(rd_lo)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        acc_valid = 0; acc_indirect = 0; acc_ptr = 0; acc_mode = 0;
        acc_wreg = 0; acc_operand = 0; wr_ptr = 0; ptr_wr_hi = 0;
        ptr_wr_lo = 0; wr_byte = 0; ptr_load = 0; load_value = 0;
        bank_load = 0; bank_value = 0; rd_sel = 0;
    endtask

    function automatic logic [11:0] exp_eff();
        logic [11:0] p;
        if (!acc_indirect) return {m_bank, acc_operand};
        if (acc_ptr == 2'd3) return 12'h000;
        p = m_ptr[acc_ptr];
        case (acc_mode)
            3'd3:    return p + 12'd1;
            3'd4:    return p + {{4{acc_wreg[7]}}, acc_wreg};
            default: return p;
        endcase
    endfunction

    task automatic model_step();
        logic [11:0] nxt [3];
        for (int i = 0; i < 3; i++) begin
            nxt[i] = m_ptr[i];
            if (ptr_load && wr_ptr == 2'(i)) begin
                nxt[i] = load_value;
            end else if ((ptr_wr_hi || ptr_wr_lo) && wr_ptr == 2'(i)) begin
                if (ptr_wr_hi) nxt[i][11:8] = wr_byte[3:0];
                if (ptr_wr_lo) nxt[i][7:0]  = wr_byte;
            end else if (acc_valid && acc_indirect && acc_ptr == 2'(i)) begin
                if (acc_mode == 3'd1) nxt[i] = m_ptr[i] - 12'd1;
                else if (acc_mode == 3'd2 || acc_mode == 3'd3) nxt[i] = m_ptr[i] + 12'd1;
            end
        end
        for (int i = 0; i < 3; i++) m_ptr[i] = nxt[i];
        if (bank_load) m_bank = bank_value;
    endtask

    task automatic check_state(string req);
        for (int s = 0; s < 4; s++) begin
            rd_sel = 2'(s);
            #1;
            check(req, {rd_hi, rd_lo}, (s == 3) ? 16'h0000 : {4'h0, m_ptr[s]});
        end
        check(req, bank_q, m_bank);
    endtask

    // Inputs are already set (low clock phase). Checks address, clocks, checks state.
    task automatic tick(string req_ea, string req_st);
        #1;
        check(req_ea, eff_addr, exp_eff());
        model_step();
        @(posedge clk);
        #1;
        check_state(req_st);
        @(negedge clk);
        idle();
    endtask

    task automatic load_ptr(logic [1:0] p, logic [11:0] v, string req);
        ptr_load = 1; wr_ptr = p; load_value = v;
        tick(req, req);
    endtask

    string mreq [8] = '{"R3", "R4", "R5", "R6", "R7", "R12", "R12", "R12"};

    initial begin
        logic [11:0] bases [6] = '{12'h000, 12'hFFF, 12'h7FF, 12'h800, 12'h001, 12'hABC};
        logic [7:0]  wvals [6] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF, 8'hC3};
        int bi = 0;
        idle();
        rst = 1;
        for (int i = 0; i < 3; i++) m_ptr[i] = 12'h000;
        m_bank = 4'h0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        check_state("R1");
        @(negedge clk);

        // R10: full loads
        load_ptr(2'd0, 12'h123, "R10");
        load_ptr(2'd1, 12'h456, "R10");
        load_ptr(2'd2, 12'hFFF, "R10");

        // R9: byte writes
        ptr_wr_lo = 1; wr_ptr = 2'd1; wr_byte = 8'hAB; tick("R9", "R9");
        ptr_wr_hi = 1; wr_ptr = 2'd2; wr_byte = 8'hF5; tick("R9", "R9");
        ptr_wr_hi = 1; ptr_wr_lo = 1; wr_ptr = 2'd0; wr_byte = 8'h9E; tick("R9", "R9");

        // Sweep over select code, mode, offset and strobe
        for (int p = 0; p < 4; p++) begin
            for (int m = 0; m < 8; m++) begin
                for (int wi = 0; wi < 6; wi++) begin
                    for (int v = 0; v < 2; v++) begin
                        load_ptr(2'(p), bases[bi], (p == 3) ? "R13" : "R10");
                        bi = (bi + 1) % 6;
                        acc_indirect = 1; acc_valid = v[0]; acc_ptr = 2'(p);
                        acc_mode = 3'(m); acc_wreg = wvals[wi];
                        acc_operand = 8'h5A;
                        tick((p == 3) ? "R13" : mreq[m],
                             (p == 3) ? "R13" : (v == 0) ? "R8" : mreq[m]);
                    end
                end
            end
        end

        // R13: byte write to no pointer
        ptr_wr_hi = 1; ptr_wr_lo = 1; wr_ptr = 2'd3; wr_byte = 8'h77; tick("R13", "R13");

        // R2: direct addressing over all bank values, modes that would modify
        for (int b = 0; b < 16; b++) begin
            bank_load = 1; bank_value = 4'(b); tick("R2", "R2");
            acc_valid = 1; acc_indirect = 0; acc_ptr = 2'(b % 3);
            acc_mode = 3'(1 + b % 3); acc_operand = 8'(b * 37 + 5);
            tick("R2", "R2");
        end

        // R11: collisions
        load_ptr(2'd0, 12'h010, "R11");
        ptr_load = 1; wr_ptr = 2'd0; load_value = 12'h3C0;
        ptr_wr_lo = 1; wr_byte = 8'h11;
        acc_valid = 1; acc_indirect = 1; acc_ptr = 2'd0; acc_mode = 3'd2;
        tick("R5", "R11");
        ptr_wr_lo = 1; wr_ptr = 2'd0; wr_byte = 8'h00;
        acc_valid = 1; acc_indirect = 1; acc_ptr = 2'd0; acc_mode = 3'd1;
        tick("R4", "R11");
        ptr_load = 1; wr_ptr = 2'd1; load_value = 12'hE01;
        acc_valid = 1; acc_indirect = 1; acc_ptr = 2'd0; acc_mode = 3'd3;
        tick("R6", "R11");
        ptr_wr_hi = 1; wr_ptr = 2'd2; wr_byte = 8'h0F;
        acc_valid = 1; acc_indirect = 1; acc_ptr = 2'd1; acc_mode = 3'd1;
        tick("R4", "R11");

        // R4/R5 wrap through repeated steps
        load_ptr(2'd2, 12'h001, "R4");
        repeat (3) begin
            acc_valid = 1; acc_indirect = 1; acc_ptr = 2'd2; acc_mode = 3'd1;
            tick("R4", "R4");
        end
        repeat (3) begin
            acc_valid = 1; acc_indirect = 1; acc_ptr = 2'd2; acc_mode = 3'd2;
            tick("R5", "R5");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule